// File: doc/BRIEF.md
# Iterative Carry-Feedback Integer Adder

This block adds two signed two's-complement integers of a configurable width. It has no carry chain. Every bit slice holds one XOR gate, which gives the partial sum bit, and one AND gate, which gives the carry bit that the slice generates. On each clock cycle the partial-sum word and the carry word, shifted up by one position, are written back into the operand registers. Carries therefore move one bit per cycle. The loop ends when no carry bit is left.

The number of cycles depends on the data. An addition whose operands share no set bit ends in one cycle. The longest carry run takes as many cycles as there are bits in the word. The block is meant for accumulation work such as the summing junction of a neuron, where many additions are done and the average carry run is short.

To use the block, pulse `start` with both operands while `busy` is low. Then wait for the single-cycle `done` strobe, and take `result` in that cycle. Any carry shifted past the top bit is dropped, so the sum wraps modulo 2^W.

Top module: `cfa_adder`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are low and `result` is zero.
- R2: A `start` seen at a clock edge while `busy` is low captures `op_a` and `op_b`, and `busy` is high from the next cycle on.
- R3: In the cycle where `done` is high, `result` equals (`op_a` + `op_b`) mod 2^W for the captured operands, with signed operands in two's complement.
- R4: `done` is high for exactly one cycle. In the cycle after it, both `busy` and `done` are low.
- R5: If the captured operands have no set bit in common (for example `op_b` zero), `done` is high in the first cycle after the capturing edge.
- R6: No addition takes more than W cycles from the capturing edge to `done`. For `op_a` all ones and `op_b` equal to one, it takes exactly W cycles.
- R7: A `start` while `busy` is high is ignored. The running addition still ends at its own cycle count, with the sum of its own operands.
- R8: Define one step as (x, y) -> (x XOR y, (x AND y) shifted left by one with a zero LSB and the top bit dropped). Start from (A, B) and let k be the number of steps until y is zero. The latency is max(1, k) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an addition when idle |
| op_a | input | W | First operand, two's complement |
| op_b | input | W | Second operand, two's complement |
| result | output | W | Sum, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | An addition is in progress |

## Verification
A corrupted partial-sum or carry register shows up in two ways at the ports. One is a wrong `result` in the `done` cycle. The other is `done` arriving earlier or later than the step count of the operand pair predicts, and the timing gives the earlier warning. For that reason every operand pair of a narrow configuration is swept, and both the sum and the exact cycle of `done` are checked. A fault in the idle/busy control shows up within one cycle: `busy` fails to rise after a `start`, stays high after `done`, or reacts to a `start` issued mid-run.

// File: rtl/cfa_pkg.sv
// Package cfa_pkg
// Shared types for the carry-feedback adder. Assumes nothing beyond IEEE 1800-2017.
package cfa_pkg;

    // Output of one bit slice: the sum bit and the carry bit it generates
    typedef struct packed {
        logic s;
        logic c;
    } bit_pair_t;

endpackage

// File: rtl/cfa_bit_slice.sv
// Module cfa_bit_slice
// One bit of the adder. An XOR gives the partial sum and an AND gives the carry
// generated here. Assumes the caller shifts the carry into the next slice.
module cfa_bit_slice
    import cfa_pkg::*;
(
    input  logic      x,
    input  logic      y,
    output bit_pair_t pr
);

    // Two gates per bit: sum and generate
    assign pr.s = x ^ y;
    assign pr.c = x & y;

endmodule

// File: rtl/cfa_zero_detect.sv
// Module cfa_zero_detect
// Flags a word with no bit set. Used to stop the carry loop.
// Assumes W >= 1.
module cfa_zero_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec,
    output logic         is_zero
);

    // Reduction NOR across the whole carry word
    assign is_zero = ~|vec;

endmodule

// File: rtl/cfa_datapath.sv
// Module cfa_datapath
// Holds the partial-sum and carry registers and the row of bit slices.
// On load the slices see the operands; on step they see the registers.
// The carry word is shifted up by one with a zero LSB, and the top carry
// is dropped, which gives wrap-around modulo 2^W. Assumes W >= 2.
module cfa_datapath
    import cfa_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum_q,
    output logic         carry_zero
);

    logic [W-1:0] car_q;
    logic [W-1:0] x_in;
    logic [W-1:0] y_in;
    logic [W-1:0] s_vec;
    logic [W-1:0] c_vec;
    logic [W-1:0] c_shift;
    logic [W-1:0] total;
    logic [W-1:0] op_total;

    // Select the slice inputs: fresh operands on load, fed-back words otherwise
    always_comb begin
        x_in = load ? op_a : sum_q;
        y_in = load ? op_b : car_q;
    end

    // One slice per bit
    generate
        for (genvar i = 0; i < W; i++) begin : g_slice
            bit_pair_t pr;
            cfa_bit_slice u_slice (
                .x  (x_in[i]),
                .y  (y_in[i]),
                .pr (pr)
            );
            assign s_vec[i] = pr.s;
            assign c_vec[i] = pr.c;
        end
    endgenerate

    // Carries move up one position; the top carry falls off
    assign c_shift = c_vec << 1;

    // Register update for both the first pass and each feedback pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            car_q <= '0;
        end else if (load || step) begin
            sum_q <= s_vec;
            car_q <= c_shift;
        end
    end

    cfa_zero_detect #(.W(W)) u_zero (
        .vec     (car_q),
        .is_zero (carry_zero)
    );

    // Words used only by the assertions below
    assign total    = sum_q + car_q;
    assign op_total = op_a + op_b;

    AST_LOAD_HOLDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> total == $past(op_total)); // R3

    AST_STEP_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> total == $past(total)); // R3

    AST_CARRY_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load || step) |=> car_q[0] == 1'b0); // R8

endmodule

// File: rtl/cfa_ctrl.sv
// Module cfa_ctrl
// Idle/busy control. Accepts a start only when idle, keeps stepping while
// carries remain, and raises done for the one cycle in which the carry word
// is zero. Assumes carry_zero comes from the registered carry word.
module cfa_ctrl #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic carry_zero,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);

    localparam int CW = $clog2(W + 2);

    logic          busy_q;
    logic [CW-1:0] cyc_q;

    assign busy = busy_q;
    assign load = start && !busy_q;
    assign done = busy_q && carry_zero;
    assign step = busy_q && !carry_zero;

    // Busy flag: set by an accepted start, cleared after the done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b1;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // Cycles spent in the current addition, used for the latency bound
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (load) begin
            cyc_q <= CW'(1);
        end else if (step) begin
            cyc_q <= cyc_q + CW'(1);
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R4

    AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_q <= CW'(W))); // R6

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R7

endmodule

// File: rtl/cfa_adder.sv
// Module cfa_adder
// Top of the carry-feedback adder. Latency depends on the data: between
// 1 and W cycles from the edge that captures start to the done strobe.
// Assumes W >= 2. result is only meaningful while done is high.
module cfa_adder #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result,
    output logic         done,
    output logic         busy
);

    logic load;
    logic step;
    logic carry_zero;

    // Control: accept, iterate, finish
    cfa_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .carry_zero (carry_zero),
        .busy       (busy),
        .done       (done),
        .load       (load),
        .step       (step)
    );

    // Data: slices plus feedback registers
    cfa_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .op_a       (op_a),
        .op_b       (op_b),
        .sum_q      (result),
        .carry_zero (carry_zero)
    );

    AST_RESULT_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result)); // R7

endmodule

// File: tb/cfa_adder_tb.sv
`timescale 1ns/1ps
// Bench for cfa_adder: every operand pair at W = 6, plus the worst case,
// a start issued mid-run, and the reset state.
module cfa_adder_tb;

    localparam int W = 6;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         done;
    logic         busy;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    cfa_adder #(.W(W)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .done   (done),
        .busy   (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Expected latency from the step definition: max(1, k)
    function automatic int exp_lat(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] x = a;
        logic [W-1:0] y = b;
        logic [W-1:0] t;
        int k = 0;
        while (y != '0) begin
            t = x ^ y;
            y = (x & y) << 1;
            x = t;
            k++;
        end
        return (k < 1) ? 1 : k;
    endfunction

    // One addition; optionally a stray start with other operands mid-run
    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit stray, output logic [W-1:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (stray && !done) begin
            start = 1'b1; op_a = 6'd5; op_b = 6'd5;
        end
        while (!done && lat <= W + 2) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        res = result;
        @(negedge clk);
        chk(!busy && !done, "R4 idle after done", int'({busy, done}), 0);
    endtask

    initial begin
        logic [W-1:0] r;
        int           lat;
        logic [W-1:0] want;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && result == '0, "R1 reset state",
            int'({busy, done, result}), 0);

        // R6 worst case: all ones plus one
        do_add('1, 6'd1, 1'b0, r, lat);
        chk(lat == W, "R6 worst case latency", lat, W);
        chk(r == '0, "R3 wrap to zero", int'(r), 0);

        // R7 stray start during a long addition
        do_add('1, 6'd1, 1'b1, r, lat);
        chk(r == '0, "R7 result after ignored start", int'(r), 0);
        chk(lat == W, "R7 latency after ignored start", lat, W);

        // R5 disjoint operands finish in one cycle
        do_add(6'd0, 6'd0, 1'b0, r, lat);
        chk(lat == 1 && r == '0, "R5 zero plus zero", lat, 1);
        do_add(6'b101010, 6'b010101, 1'b0, r, lat);
        chk(lat == 1 && r == 6'b111111, "R5 disjoint bits", lat, 1);

        // R3 signed cases: -3 + -5 = -8, 31 + 1 wraps to -32
        do_add(6'b111101, 6'b111011, 1'b0, r, lat);
        chk(r == 6'b111000, "R3 negative sum", int'(r), 56);
        do_add(6'd31, 6'd1, 1'b0, r, lat);
        chk(r == 6'b100000, "R3 signed wrap", int'(r), 32);

        // R3 R8 R6 exhaustive sweep
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                do_add(W'(a), W'(b), 1'b0, r, lat);
                want = W'(a + b);
                chk(r == want, "R3 sum", int'(r), int'(want));
                chk(lat == exp_lat(W'(a), W'(b)), "R8 latency", lat,
                    exp_lat(W'(a), W'(b)));
                chk(lat <= W, "R6 bound", lat, W);
            end
        end
        finish_run();
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule